// File: doc/BRIEF.md
# Immediate Accumulator ALU

This block executes a family of two-word instructions that combine one of two 40-bit accumulators with a 16-bit immediate operand. The instruction fetch side presents words one at a time, each qualified by `wordValid`. The first word holds the operation, and the second word is the raw immediate. The block waits in between for as many idle cycles as the fetch side needs.

Each accumulator is split into an 8-bit high part, a 16-bit mid part and a 16-bit low part. The operations are:

- add, which places the sign-extended immediate at the mid position;
- bitwise XOR, AND and OR on the mid part;
- a compare that writes no register;
- two bit tests, which affect only a logic-zero flag.

The status flags are zero, sign, carry, overflow and logic-zero. A one-cycle `done` pulse marks each completed instruction. A one-cycle `illegal` pulse marks a rejected first word. A separate load port lets the surrounding core write either accumulator directly.

Top module: `imm_acc_alu`

## Requirements
- R1: A word accepted while idle is an instruction when bits 15..9 equal 0000001 and bits 4..0 are zero. Bits 7..5 give the operation and must not be 111. Bit 8 picks the accumulator: 0 selects acc0 and 1 selects acc1. The other accumulator is never written.
- R2: Nothing changes until a second valid word arrives. In the cycle after that word is sampled, `done` is high for one cycle and the new accumulator and flag values are visible.
- R3: Operation 000 adds the immediate, sign-extended and shifted left by 16, to the 40-bit accumulator. The low 16 bits are kept. Zero and sign are taken from the 40-bit result. Carry is the carry out of bit 39. Overflow is the signed 40-bit overflow. Logic-zero is kept.
- R4: Operations 001, 010 and 011 replace the mid part with mid XOR I, mid AND I and mid OR I respectively. The high and low parts are kept. Zero and sign come from the 16-bit result. Carry and overflow are cleared. Logic-zero is kept.
- R5: Operation 100 computes the accumulator minus the shifted, sign-extended immediate over 40 bits and writes no accumulator. Zero, sign and signed overflow come from that difference. Carry is 1 exactly when there is no borrow (unsigned accumulator ≥ operand). Logic-zero is kept.
- R6: Operation 110 sets logic-zero when (mid AND I) equals I and clears it otherwise.
- R7: Operation 101 sets logic-zero when (mid AND I) equals zero and clears it otherwise.
- R8: The two bit tests write no accumulator and leave zero, sign, carry and overflow unchanged.
- R9: A first word that does not match, or that carries operation 111, raises `illegal` for one cycle and changes no accumulator or flag. The next valid word is again decoded as a first word.
- R10: After reset both accumulators and all five flags are zero, and `done` and `illegal` are low.
- R11: When `loadEn` is high, `loadValue` is written at the clock edge into acc1 if `loadSel` is 1, otherwise into acc0.
- R12: Cycles with `wordValid` low between the two words have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wordValid | input | 1 | Qualifies wordData |
| wordData | input | 16 | Instruction word, then immediate word |
| loadEn | input | 1 | Direct accumulator write strobe |
| loadSel | input | 1 | Direct write target (0: acc0, 1: acc1) |
| loadValue | input | 40 | Direct write value |
| acc0 | output | 40 | Accumulator 0 |
| acc1 | output | 40 | Accumulator 1 |
| flagZero | output | 1 | Zero flag |
| flagSign | output | 1 | Sign flag |
| flagCarry | output | 1 | Carry flag |
| flagOvf | output | 1 | Overflow flag |
| flagLz | output | 1 | Logic-zero flag |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle rejected-opcode pulse |

## Verification
The hardest conditions to reach are the 40-bit overflow and borrow corners of add and compare. These need an accumulator sitting just beside the signed limit, combined with an immediate whose sign extension fills the high byte. The bench preloads both accumulators through the load port with values chosen at those limits. It then sweeps every operation against both destinations and a set of immediates that includes 0x7FFF, 0x8000 and 0xFFFF. Idle gaps of varying length are inserted between the two words.

// File: rtl/imm_alu_pkg.sv
package imm_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD    = 3'b000,
    OP_XOR    = 3'b001,
    OP_AND    = 3'b010,
    OP_OR     = 3'b011,
    OP_CMP    = 3'b100,
    OP_TSTNONE = 3'b101,
    OP_TSTALL = 3'b110,
    OP_BAD    = 3'b111
  } subop_e;

  typedef struct packed {
    logic   exec;
    logic   dsel;
    subop_e op;
  } ctrl_s;

  typedef struct packed {
    logic zero;
    logic sign;
    logic carry;
    logic ovf;
    logic lz;
  } flags_s;

endpackage

// File: rtl/imm_alu_ctrl.sv
module imm_alu_ctrl
  import imm_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic [DATA_W-1:0] wordData,
  output ctrl_s             ctrl,
  output logic              done,
  output logic              illegal
);

  localparam int PFX_W = DATA_W - 9;

  typedef enum logic {ST_IDLE, ST_IMM} state_e;

  state_e stateQ;
  logic   dselQ;
  subop_e opQ;
  logic   prefixOk;
  logic   tailOk;
  logic   decodeOk;
  logic   accept;
  logic   reject;
  subop_e wordOp;

  // Decode the fields of a candidate first word.
  always_comb begin
    wordOp   = subop_e'(wordData[7:5]);
    prefixOk = (wordData[DATA_W-1:9] == PFX_W'(1));
    tailOk   = (wordData[4:0] == 5'd0);
    decodeOk = prefixOk && tailOk && (wordOp != OP_BAD);
    accept   = (stateQ == ST_IDLE) && wordValid && decodeOk;
    reject   = (stateQ == ST_IDLE) && wordValid && !decodeOk;
  end

  always_comb begin
    ctrl.exec = (stateQ == ST_IMM) && wordValid;
    ctrl.dsel = dselQ;
    ctrl.op   = opQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      dselQ   <= 1'b0;
      opQ     <= OP_ADD;
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done    <= ctrl.exec;
      illegal <= reject;
      if (accept) begin
        stateQ <= ST_IMM;
        dselQ  <= wordData[8];
        opQ    <= wordOp;
      end else if (ctrl.exec) begin
        stateQ <= ST_IDLE;
      end
    end
  end

endmodule

// File: rtl/imm_alu_dp.sv
module imm_alu_dp
  import imm_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int HIGH_W = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrl_s                        ctrl,
  input  logic [DATA_W-1:0]            imm,
  input  logic                         loadEn,
  input  logic                         loadSel,
  input  logic [HIGH_W+2*DATA_W-1:0]   loadValue,
  output logic [HIGH_W+2*DATA_W-1:0]   acc0,
  output logic [HIGH_W+2*DATA_W-1:0]   acc1,
  output flags_s                       flags
);

  localparam int ACC_W   = HIGH_W + 2 * DATA_W;
  localparam int MSB     = ACC_W - 1;
  localparam int MID_LO  = DATA_W;
  localparam int MID_HI  = 2 * DATA_W - 1;
  localparam int NUM_ACC = 2;

  logic [NUM_ACC-1:0][ACC_W-1:0] accBus;
  logic [ACC_W-1:0]  accCur;
  logic [ACC_W-1:0]  immExt;
  logic [ACC_W:0]    sumAdd;
  logic [ACC_W:0]    sumSub;
  logic [DATA_W-1:0] mid;
  logic [DATA_W-1:0] masked;
  logic [DATA_W-1:0] logicRes;
  logic [ACC_W-1:0]  nextAcc;
  logic              writeAcc;
  flags_s            flagsQ;
  flags_s            nextFlags;

  // Operand formation: immediate sign-extended and placed at the mid slot.
  always_comb begin
    accCur = accBus[ctrl.dsel];
    immExt = {{HIGH_W{imm[DATA_W-1]}}, imm, {DATA_W{1'b0}}};
    sumAdd = {1'b0, accCur} + {1'b0, immExt};
    sumSub = {1'b0, accCur} + {1'b0, ~immExt} + (ACC_W + 1)'(1);
    mid    = accCur[MID_HI:MID_LO];
    masked = mid & imm;
  end

  always_comb begin
    logicRes = mid;
    case (ctrl.op)
      OP_XOR:  logicRes = mid ^ imm;
      OP_AND:  logicRes = masked;
      OP_OR:   logicRes = mid | imm;
      default: logicRes = mid;
    endcase
  end

  always_comb begin
    nextAcc   = accCur;
    nextFlags = flagsQ;
    writeAcc  = 1'b0;
    case (ctrl.op)
      OP_ADD: begin
        writeAcc        = 1'b1;
        nextAcc         = sumAdd[ACC_W-1:0];
        nextFlags.zero  = (sumAdd[ACC_W-1:0] == '0);
        nextFlags.sign  = sumAdd[MSB];
        nextFlags.carry = sumAdd[ACC_W];
        nextFlags.ovf   = (accCur[MSB] == immExt[MSB]) && (sumAdd[MSB] != accCur[MSB]);
      end
      OP_XOR, OP_AND, OP_OR: begin
        writeAcc        = 1'b1;
        nextAcc         = {accCur[ACC_W-1:MID_HI+1], logicRes, accCur[MID_LO-1:0]};
        nextFlags.zero  = (logicRes == '0);
        nextFlags.sign  = logicRes[DATA_W-1];
        nextFlags.carry = 1'b0;
        nextFlags.ovf   = 1'b0;
      end
      OP_CMP: begin
        nextFlags.zero  = (sumSub[ACC_W-1:0] == '0);
        nextFlags.sign  = sumSub[MSB];
        nextFlags.carry = sumSub[ACC_W];
        nextFlags.ovf   = (accCur[MSB] != immExt[MSB]) && (sumSub[MSB] != accCur[MSB]);
      end
      OP_TSTALL:  nextFlags.lz = (masked == imm);
      OP_TSTNONE: nextFlags.lz = (masked == '0);
      default: ;
    endcase
  end

  for (genvar g = 0; g < NUM_ACC; g++) begin : gAcc
    logic [ACC_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rstN)
        q <= '0;
      else if (ctrl.exec && writeAcc && (ctrl.dsel == 1'(g)))
        q <= nextAcc;
      else if (loadEn && (loadSel == 1'(g)))
        q <= loadValue;
    end
    assign accBus[g] = q;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      flagsQ <= '0;
    else if (ctrl.exec)
      flagsQ <= nextFlags;
  end

  assign acc0  = accBus[0];
  assign acc1  = accBus[1];
  assign flags = flagsQ;

endmodule

// File: rtl/imm_acc_alu.sv
module imm_acc_alu
  import imm_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int HIGH_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wordValid,
  input  logic [DATA_W-1:0]          wordData,
  input  logic                       loadEn,
  input  logic                       loadSel,
  input  logic [HIGH_W+2*DATA_W-1:0] loadValue,
  output logic [HIGH_W+2*DATA_W-1:0] acc0,
  output logic [HIGH_W+2*DATA_W-1:0] acc1,
  output logic                       flagZero,
  output logic                       flagSign,
  output logic                       flagCarry,
  output logic                       flagOvf,
  output logic                       flagLz,
  output logic                       done,
  output logic                       illegal
);

  ctrl_s  ctrl;
  flags_s flags;

  imm_alu_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordData(wordData),
    .ctrl(ctrl), .done(done), .illegal(illegal)
  );

  imm_alu_dp #(.DATA_W(DATA_W), .HIGH_W(HIGH_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .imm(wordData),
    .loadEn(loadEn), .loadSel(loadSel), .loadValue(loadValue),
    .acc0(acc0), .acc1(acc1), .flags(flags)
  );

  assign flagZero  = flags.zero;
  assign flagSign  = flags.sign;
  assign flagCarry = flags.carry;
  assign flagOvf   = flags.ovf;
  assign flagLz    = flags.lz;

endmodule

// File: rtl/imm_acc_alu_chk.sv
module imm_acc_alu_chk #(
  parameter int DATA_W = 16,
  parameter int HIGH_W = 8
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       wordValid,
  input logic [DATA_W-1:0]          wordData,
  input logic                       loadEn,
  input logic                       loadSel,
  input logic [HIGH_W+2*DATA_W-1:0] loadValue,
  input logic [HIGH_W+2*DATA_W-1:0] acc0,
  input logic [HIGH_W+2*DATA_W-1:0] acc1,
  input logic                       flagZero,
  input logic                       flagSign,
  input logic                       flagCarry,
  input logic                       flagOvf,
  input logic                       flagLz,
  input logic                       done,
  input logic                       illegal
);

  a_r9_pulses_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(done && illegal));

  a_r2_done_follows_word: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(wordValid));

  a_r2_arith_flags_only_on_done: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({flagZero, flagSign, flagCarry, flagOvf}) |-> done);

  a_r8_lz_change_is_test_only: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(flagLz) && !$past(loadEn)) |->
      (done && $stable({flagZero, flagSign, flagCarry, flagOvf}) && $stable(acc0) && $stable(acc1)));

  a_r9_illegal_no_change: assert property (@(posedge clk) disable iff (!rstN)
    (illegal && !$past(loadEn)) |->
      ($stable(acc0) && $stable(acc1) && $stable({flagZero, flagSign, flagCarry, flagOvf, flagLz})));

endmodule

bind imm_acc_alu imm_acc_alu_chk #(.DATA_W(DATA_W), .HIGH_W(HIGH_W)) u_chk (.*);

// File: tb/sim_imm_acc_alu.sv
`timescale 1ns/100ps
module sim_imm_acc_alu;

  localparam longint MASK40 = (64'd1 << 40) - 1;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wordValid;
  logic [15:0] wordData;
  logic        loadEn;
  logic        loadSel;
  logic [39:0] loadValue;
  logic [39:0] acc0, acc1;
  logic        flagZero, flagSign, flagCarry, flagOvf, flagLz;
  logic        done, illegal;

  int checks = 0;
  int fails  = 0;

  logic [39:0] mAcc [2];
  logic [4:0]  mFlags; // {zero, sign, carry, ovf, lz}

  imm_acc_alu u0 (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordData(wordData),
    .loadEn(loadEn), .loadSel(loadSel), .loadValue(loadValue),
    .acc0(acc0), .acc1(acc1), .flagZero(flagZero), .flagSign(flagSign),
    .flagCarry(flagCarry), .flagOvf(flagOvf), .flagLz(flagLz),
    .done(done), .illegal(illegal)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkState(input string req, input logic d);
    check(req, "selected acc", d ? acc1 : acc0, mAcc[d]);
    check("R1", "other acc", d ? acc0 : acc1, mAcc[!d]);
    check(req, "flags", 40'({flagZero, flagSign, flagCarry, flagOvf, flagLz}), 40'(mFlags));
  endtask

  function automatic longint sx40(input longint x);
    return x[39] ? x - (64'sd1 <<< 40) : x;
  endfunction

  task automatic loadAcc(input logic sel, input logic [39:0] val);
    @(negedge clk);
    loadEn = 1'b1; loadSel = sel; loadValue = val;
    @(negedge clk);
    loadEn = 1'b0;
    mAcc[sel] = val;
  endtask

  task automatic model(input logic [2:0] op, input logic d, input logic [15:0] imm);
    longint a, b, r, sa, sb, ss;
    longint mid;
    longint lr;
    a   = longint'(mAcc[d]);
    b   = ((imm[15] ? longint'(imm) - 65536 : longint'(imm)) * 65536) & MASK40;
    sa  = sx40(a);
    sb  = sx40(b);
    mid = (a >> 16) & 64'hFFFF;
    case (op)
      3'd0: begin // R3
        r = a + b;
        mFlags[2] = r[40];
        r = r & MASK40;
        ss = sa + sb;
        mFlags[1] = (ss > 64'sd549755813887) || (ss < -64'sd549755813888);
        mFlags[4] = (r == 0);
        mFlags[3] = r[39];
        mAcc[d] = r[39:0];
      end
      3'd1, 3'd2, 3'd3: begin // R4
        if (op == 3'd1)      lr = mid ^ longint'(imm);
        else if (op == 3'd2) lr = mid & longint'(imm);
        else                 lr = mid | longint'(imm);
        mAcc[d][31:16] = lr[15:0];
        mFlags[4] = (lr == 0);
        mFlags[3] = lr[15];
        mFlags[2] = 1'b0;
        mFlags[1] = 1'b0;
      end
      3'd4: begin // R5
        r = (a - b) & MASK40;
        ss = sa - sb;
        mFlags[2] = (a >= b);
        mFlags[1] = (ss > 64'sd549755813887) || (ss < -64'sd549755813888);
        mFlags[4] = (r == 0);
        mFlags[3] = r[39];
      end
      3'd5: mFlags[0] = ((mid & longint'(imm)) == 0);              // R7
      default: mFlags[0] = ((mid & longint'(imm)) == longint'(imm)); // R6
    endcase
  endtask

  function automatic string reqOf(input logic [2:0] op);
    case (op)
      3'd0: return "R3";
      3'd1, 3'd2, 3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic runOp(input logic [2:0] op, input logic d, input logic [15:0] imm, input int gap);
    @(negedge clk);
    wordValid = 1'b1;
    wordData  = 16'h0200 | (16'(d) << 8) | (16'(op) << 5);
    @(negedge clk);
    wordValid = 1'b0;
    wordData  = 16'hFFFF;
    if (gap > 0) begin
      repeat (gap) @(negedge clk);
      check("R12", "done during gap", 40'(done), 40'd0);
      check("R12", "acc during gap", d ? acc1 : acc0, mAcc[d]);
    end
    wordValid = 1'b1;
    wordData  = imm;
    @(negedge clk);
    wordValid = 1'b0;
    model(op, d, imm);
    check("R2", "done pulse", 40'(done), 40'd1);
    checkState(reqOf(op), d);
    if (op >= 3'd5) check("R8", "test keeps acc", d ? acc1 : acc0, mAcc[d]);
  endtask

  task automatic badWord(input logic [15:0] w);
    @(negedge clk);
    wordValid = 1'b1; wordData = w;
    @(negedge clk);
    wordValid = 1'b0;
    check("R9", "illegal pulse", 40'(illegal), 40'd1);
    check("R9", "no done", 40'(done), 40'd0);
    checkState("R9", 1'b0);
    check("R9", "acc1 unchanged", acc1, mAcc[1]);
    @(negedge clk);
    check("R9", "illegal clears", 40'(illegal), 40'd0);
  endtask

  logic [39:0] accVals [8];
  logic [15:0] immVals [8];

  initial begin
    #(200000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    accVals[0] = 40'h00_0000_0000; accVals[1] = 40'h7F_FFFF_0000;
    accVals[2] = 40'h80_0000_0000; accVals[3] = 40'hFF_FFFF_FFFF;
    accVals[4] = 40'h00_1234_5678; accVals[5] = 40'h00_FFFF_0001;
    accVals[6] = 40'hFF_8000_1234; accVals[7] = 40'h00_0000_8001;
    immVals[0] = 16'h0000; immVals[1] = 16'h0001;
    immVals[2] = 16'h7FFF; immVals[3] = 16'h8000;
    immVals[4] = 16'hFFFF; immVals[5] = 16'h1234;
    immVals[6] = 16'h00F0; immVals[7] = 16'hA5A5;

    rstN = 1'b0; wordValid = 1'b0; wordData = '0;
    loadEn = 1'b0; loadSel = 1'b0; loadValue = '0;
    mAcc[0] = '0; mAcc[1] = '0; mFlags = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10", "acc0 reset", acc0, 40'd0);
    check("R10", "acc1 reset", acc1, 40'd0);
    check("R10", "flags reset", 40'({flagZero, flagSign, flagCarry, flagOvf, flagLz}), 40'd0);
    check("R10", "pulses reset", 40'({done, illegal}), 40'd0);

    loadAcc(1'b1, 40'h12_3456_789A);
    check("R11", "load acc1", acc1, 40'h12_3456_789A);
    check("R11", "acc0 untouched", acc0, 40'd0);

    badWord(16'h02E0);
    badWord(16'h03E0);
    badWord(16'h0201);
    badWord(16'h0600);
    badWord(16'h0000);
    badWord(16'hFFFF);

    for (int d = 0; d < 2; d++) begin
      for (int op = 0; op < 7; op++) begin
        for (int ai = 0; ai < 8; ai++) begin
          loadAcc(1'(d), accVals[ai]);
          loadAcc(1'(1 - d), accVals[7 - ai]);
          check("R11", "loaded", d ? acc1 : acc0, accVals[ai]);
          for (int ii = 0; ii < 8; ii++) begin
            runOp(3'(op), 1'(d), immVals[ii], ii % 3);
          end
        end
      end
    end

    runOp(3'd0, 1'b0, 16'h0010, 0);
    @(negedge clk);
    check("R2", "done one cycle", 40'(done), 40'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule